// File: doc/BRIEF.md
# Loadable Output Credit Counter

This block keeps the flow-control credit balance for one output channel that feeds a downstream consumer. A sender offers a message by raising a valid line. The block accepts it with an acknowledge in the same cycle, but only when at least one credit is left, and each accepted message spends one credit. The consumer gives credits back with a one-cycle return pulse, and each pulse restores one credit. The balance can never go above a configured maximum. A return that would exceed the maximum is discarded, and a sticky overflow flag records the event.

A single configuration port serves two purposes. Writing to it loads a new starting balance. Its read side always shows the live balance, so the value seen there after a write moves as traffic flows. An interface-enable input controls the handshake. While it is low, offered messages are ignored and acknowledge stays low. Credit returns and configuration loads keep working as normal. The counter width, the maximum credit and the balance after reset are parameters, so the same block can serve channels whose limits are 15, 32 or 255 credits.

Top module: `credit_counter`

## Requirements
- R1: In the cycle after a synchronous reset, `credit_now` equals INIT_CREDIT, `credit_ovf` is 0 and `credit_avail` is 1 when INIT_CREDIT is non-zero.
- R2: A cycle with `cfg_wr` high sets `credit_now` to `cfg_wdata` on the next cycle, or to MAX_CREDIT if `cfg_wdata` is larger. The same load clears `credit_ovf`, and `src_ack` stays low during the load cycle.
- R3: `credit_now` always shows the live balance, which changes one clock after the event that alters it.
- R4: `src_ack` is high in a cycle exactly when `if_en`, `src_valid` and `credit_avail` are all high and `cfg_wr` is low. An acknowledged cycle with no return lowers the balance by one.
- R5: When the balance is zero, `credit_avail` is 0 and `src_ack` stays low for any `src_valid`.
- R6: A `cred_return` pulse with no acknowledge in the same cycle raises the balance by one, provided the balance is below MAX_CREDIT.
- R7: An acknowledge and a return in the same cycle leave the balance unchanged.
- R8: A return with no acknowledge while the balance equals MAX_CREDIT is dropped. The balance stays at MAX_CREDIT and `credit_ovf` goes to 1 and stays there until the next load or reset.
- R9: While `if_en` is 0, `src_ack` is 0 whatever `src_valid` does, but returns and loads still change the balance.
- R10: `credit_avail` is 1 exactly when `credit_now` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Handshake enable; when low, valid is ignored and acknowledge is held low |
| src_valid | input | 1 | Sender offers a message |
| src_ack | output | 1 | Message accepted; spends one credit |
| cred_return | input | 1 | Consumer returns one credit |
| cfg_wr | input | 1 | Load strobe for the starting balance |
| cfg_wdata | input | CNT_W | Balance to load |
| credit_now | output | CNT_W | Live credit balance (read side of the configuration port) |
| credit_avail | output | 1 | Balance is non-zero |
| credit_ovf | output | 1 | Sticky flag: a return was dropped at the maximum |

## Verification
Directed phases come first. The balance is drained to zero by back-to-back offers, which shows that spending stops exactly at zero rather than wrapping. It is then refilled by returns alone, which checks increment and saturation separately from spending. Offers are made together with returns at both ends of the range, which tells a true hold apart from a decrement followed by an increment. Offers with the enable low show that the gate blocks only the handshake and not the returns. Loads are made with values below, at and above the maximum, and during live traffic, which confirms that a load wins over a same-cycle offer and clears the overflow flag. A long random mix of all inputs is then compared, cycle by cycle, against a behavioural balance model.

// File: rtl/credit_pkg.sv
package credit_pkg;
  typedef enum logic [2:0] {
    UPD_HOLD,
    UPD_DEC,
    UPD_INC,
    UPD_DROP,
    UPD_LOAD
  } upd_e;
endpackage

// File: rtl/credit_gate.sv
module credit_gate (
  input  logic if_en,
  input  logic src_valid,
  input  logic loading,
  input  logic has_credit,
  output logic take
);
  // Handshake accepted only when enabled, credit is left and no load this cycle
  always_comb begin
    take = if_en & src_valid & has_credit & ~loading;
  end
endmodule

// File: rtl/credit_store.sv
module credit_store
  import credit_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int MAX_CREDIT  = 32,
  parameter int INIT_CREDIT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  input  logic             ret,
  output logic [CNT_W-1:0] cnt,
  output logic             avail,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] MAXV  = CNT_W'(MAX_CREDIT);
  localparam logic [CNT_W-1:0] INITV = CNT_W'(INIT_CREDIT);

  upd_e             op;
  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n;

  always_comb begin
    if (load)              op = UPD_LOAD;
    else if (take && ret)  op = UPD_HOLD;
    else if (take)         op = UPD_DEC;
    else if (ret)          op = (cnt == MAXV) ? UPD_DROP : UPD_INC;
    else                   op = UPD_HOLD;
  end

  always_comb begin
    cnt_n = cnt;
    ovf_n = ovf;
    case (op)
      UPD_LOAD: begin
        cnt_n = (load_val > MAXV) ? MAXV : load_val;
        ovf_n = 1'b0;
      end
      UPD_DEC:  cnt_n = cnt - 1'b1;
      UPD_INC:  cnt_n = cnt + 1'b1;
      UPD_DROP: ovf_n = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= INITV;
      avail <= (INITV != '0);
      ovf   <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      avail <= (cnt_n != '0);
      ovf   <= ovf_n;
    end
  end

  // R10: the registered availability flag tracks the count
  assert_avail_match_R10: assert property (@(posedge clk) disable iff (rst)
    avail == (cnt != '0));

  // R8: a return at the ceiling is dropped and flagged
  assert_drop_at_max_R8: assert property (@(posedge clk) disable iff (rst)
    (ret && !take && !load && cnt == MAXV) |=> (cnt == MAXV) && ovf);

  // R7: spend and return together hold the balance
  assert_even_swap_R7: assert property (@(posedge clk) disable iff (rst)
    (ret && take && !load) |=> $stable(cnt));

  // R2: loads never leave the balance above the ceiling and clear the flag
  assert_load_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt <= MAXV) && !ovf);
endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int CNT_W       = 6,
  parameter int MAX_CREDIT  = 32,
  parameter int INIT_CREDIT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             if_en,
  input  logic             src_valid,
  output logic             src_ack,
  input  logic             cred_return,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] credit_now,
  output logic             credit_avail,
  output logic             credit_ovf
);
  logic take;

  credit_gate u_gate (
    .if_en      (if_en),
    .src_valid  (src_valid),
    .loading    (cfg_wr),
    .has_credit (credit_avail),
    .take       (take)
  );

  credit_store #(
    .CNT_W       (CNT_W),
    .MAX_CREDIT  (MAX_CREDIT),
    .INIT_CREDIT (INIT_CREDIT)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_wr),
    .load_val (cfg_wdata),
    .take     (take),
    .ret      (cred_return),
    .cnt      (credit_now),
    .avail    (credit_avail),
    .ovf      (credit_ovf)
  );

  assign src_ack = take;

  // R5: no acknowledge with an empty balance
  assert_no_send_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (credit_now == '0) |-> !src_ack);

  // R9: enable low masks the handshake
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    !if_en |-> !src_ack);

  // R4: a lone acknowledge spends exactly one credit
  assert_spend_one_R4: assert property (@(posedge clk) disable iff (rst)
    (src_ack && !cred_return) |=> credit_now == $past(credit_now) - 1'b1);
endmodule

// File: tb/sim_credit_counter.sv
module sim_credit_counter;
  localparam int W   = 6;
  localparam int MAX = 32;
  localparam int INI = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         if_en, src_valid, cred_return, cfg_wr;
  logic [W-1:0] cfg_wdata;
  logic         src_ack, credit_avail, credit_ovf;
  logic [W-1:0] credit_now;

  int checks = 0;
  int fails  = 0;
  int m_cnt;
  int m_ovf;
  bit done = 0;

  always #4 clk = ~clk;

  credit_counter #(.CNT_W(W), .MAX_CREDIT(MAX), .INIT_CREDIT(INI)) u0 (
    .clk(clk), .rst(rst), .if_en(if_en), .src_valid(src_valid),
    .src_ack(src_ack), .cred_return(cred_return), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .credit_now(credit_now),
    .credit_avail(credit_avail), .credit_ovf(credit_ovf)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check, advance model, wait to next negedge
  task automatic step(string tag, bit en, bit v, bit r, bit wr, int wd);
    int exp_ack;
    if_en = en; src_valid = v; cred_return = r; cfg_wr = wr;
    cfg_wdata = W'(wd);
    #1;
    exp_ack = (en && v && !wr && m_cnt > 0) ? 1 : 0;
    chk(tag, "credit_now", int'(credit_now), m_cnt);
    chk(tag, "credit_avail", int'(credit_avail), (m_cnt != 0) ? 1 : 0);
    chk(tag, "credit_ovf", int'(credit_ovf), m_ovf);
    chk(tag, "src_ack", int'(src_ack), exp_ack);
    if (wr) begin
      m_cnt = (wd > MAX) ? MAX : wd;
      m_ovf = 0;
    end else if (exp_ack == 1 && r) begin
      m_cnt = m_cnt;
    end else if (exp_ack == 1) begin
      m_cnt = m_cnt - 1;
    end else if (r) begin
      if (m_cnt == MAX) m_ovf = 1;
      else m_cnt = m_cnt + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; if_en = 0; src_valid = 0; cred_return = 0; cfg_wr = 0;
    cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = INI; m_ovf = 0;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 0);
    // R8 return at the ceiling is dropped and flag sticks
    step("R8", 1, 0, 1, 0, 0);
    step("R8", 1, 0, 0, 0, 0);
    // R2 load small value clears flag; R3 live readback
    step("R2", 1, 1, 0, 1, 3);
    step("R3", 1, 1, 0, 0, 0);
    // R4/R5 drain to zero, then offers are refused
    for (int i = 0; i < 4; i++) step("R5", 1, 1, 0, 0, 0);
    // R7 swap at zero: no ack, so return counts
    step("R7", 1, 1, 1, 0, 0);
    step("R7", 1, 1, 1, 0, 0);
    // R6 refill by returns
    for (int i = 0; i < 5; i++) step("R6", 1, 0, 1, 0, 0);
    // R9 enable low: offers ignored, returns still counted
    for (int i = 0; i < 3; i++) step("R9", 0, 1, 0, 0, 0);
    step("R9", 0, 1, 1, 0, 0);
    // R2 load above max clamps
    step("R2", 1, 0, 0, 1, 40);
    step("R2", 1, 1, 1, 0, 0);
    // R7 swap at ceiling holds, no overflow
    step("R7", 1, 1, 1, 0, 0);
    step("R8", 1, 0, 1, 0, 0);
    step("R2", 1, 1, 0, 1, MAX);
    step("R2", 1, 0, 0, 1, 0);
    step("R5", 1, 1, 0, 0, 0);
    // Random mix, R3 and R10 on every cycle
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      step("R3", ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, k < 3, $urandom_range(0, 63));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule